// File: doc/BRIEF.md
# March RAM Test Controller

This block runs a fixed six-element March test over a region of 32-bit words held in a synchronous RAM. Software or a boot sequencer places a word-aligned base address and an end address on the inputs and pulses `start`. The controller then drives the memory port one access at a time. It first clears every word. Next it makes four read-verify-invert sweeps whose direction alternates between ascending and descending. It ends with an ascending read-only sweep that expects every word to be zero.

The test halts at the first word whose read data differs from the expected solid pattern. The differing bits are ORed into `fail_mask` and the run ends with a one-cycle `done` pulse. A clean run also ends with `done`, and `fail_mask` is then zero. The mask holds its value until the next start. The read path takes any latency, because the controller waits for `mem_rvalid`. A parameter selects whether the comparison result is registered before the sequencer acts on it.

Top module: `mtest_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `busy`, `done` and `mem_req` are 0 and `fail_mask` is all zeros.
- R2: The first element writes 0x00000000 to each word from `base_addr` upward in steps of 4, ending at `end_addr - 4`. Every access stays inside [`base_addr`, `end_addr`).
- R3: The second element sweeps upward. For each word it reads, expects 0x00000000, and then writes 0xFFFFFFFF to the same address. Every write carries either all zeros or all ones.
- R4: The third element sweeps downward from `end_addr - 4` to `base_addr`. For each word it reads, expects 0xFFFFFFFF, and then writes 0x00000000.
- R5: The fourth element repeats the upward read-0/write-1 sweep and the fifth repeats the downward read-1/write-0 sweep. The access order and data match the second and third elements.
- R6: The sixth element sweeps upward with reads only and expects 0x00000000. A clean run on N words therefore makes exactly 5N reads and 5N writes.
- R7: At the first read whose data differs from the expected value, no further memory request is issued. `fail_mask` becomes the read data XOR the expected value and `done` follows.
- R8: `done` is high for exactly one cycle at the end of every run, whether it passed or failed. `busy` is high from the cycle after `start` through the `done` cycle and low afterwards. `mem_req` is asserted only while `busy` is high.
- R9: The word count is (`end_addr` - `base_addr`) / 4. If `end_addr` <= `base_addr` the run makes no memory access, gives `done` and leaves `fail_mask` at zero. Both addresses are word aligned, with bits [1:0] equal to 0.
- R10: A `start` pulse while `busy` is high is ignored. The access sequence of the run in progress is unchanged.
- R11: `fail_mask` keeps its value after `done` until the next accepted `start` clears it, and a following clean run reports zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse to begin a run when idle |
| base_addr | input | ADDR_W | Byte address of the first word of the region |
| end_addr | input | ADDR_W | Byte address one past the last word of the region |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail_mask | output | DATA_W | Failing bits of the first mismatching word, zero on pass |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data |
| mem_rvalid | input | 1 | Read data valid, one per read request |

## Verification
The bench attaches a behavioural RAM and records every access the controller makes. For fault-free regions of eight words and of one word, it checks the full address, direction and data order of all six elements, which confirms the sweep directions and the start point of the downward sweeps. A stuck-at-one bit is injected that the first upward verify catches, and separately a stuck-at-zero bit that survives until the first downward verify. These two runs show where the test stops, how many accesses it made, and which bit it reports. Further runs cover an empty region, a second `start` during a run, and a clean run after a failed one, which shows that the mask is cleared.

// File: rtl/mtest_pkg.sv
package mtest_pkg;

   typedef enum logic [2:0] {
      EL_FILL0  = 3'd0,
      EL_UP_A   = 3'd1,
      EL_DN_A   = 3'd2,
      EL_UP_B   = 3'd3,
      EL_DN_B   = 3'd4,
      EL_VERIFY = 3'd5
   } elem_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_WAIT,
      ST_WRITE,
      ST_DONE
   } state_e;

   function automatic logic el_reads(elem_e e);
      return e != EL_FILL0;
   endfunction

   function automatic logic el_writes(elem_e e);
      return e != EL_VERIFY;
   endfunction

   function automatic logic el_down(elem_e e);
      return (e == EL_DN_A) || (e == EL_DN_B);
   endfunction

   function automatic logic el_write_ones(elem_e e);
      return (e == EL_UP_A) || (e == EL_UP_B);
   endfunction

endpackage

// File: rtl/mtest_addr.sv
module mtest_addr #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [ADDR_W-1:0] end_i,
   input  logic              clr_i,
   input  logic              inc_i,
   input  logic              down_i,
   input  logic              req_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              last_o,
   output logic              empty_o
);
   localparam int CNT_W = ADDR_W - 2;

   logic [ADDR_W-1:0] base_q, end_q, span, offset;
   logic [CNT_W-1:0]  count_q, idx_q;

   assign span    = end_i - base_i;
   assign empty_o = (end_i <= base_i) || (span[ADDR_W-1:2] == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q  <= '0;
         end_q   <= '0;
         count_q <= '0;
      end else if (load_i) begin
         base_q  <= base_i;
         end_q   <= end_i;
         count_q <= span[ADDR_W-1:2];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     idx_q <= '0;
      else if (clr_i) idx_q <= '0;
      else if (inc_i) idx_q <= idx_q + 1'b1;
   end

   assign offset = {idx_q, 2'b00};
   assign addr_o = down_i ? (end_q - ADDR_W'(4) - offset) : (base_q + offset);
   assign last_o = (idx_q == count_q - 1'b1);

   AST_ADDR_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
      req_i |-> (addr_o >= base_q) && (addr_o < end_q) && (addr_o[1:0] == 2'b00)); // R2

   AST_LOAD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> (span[1:0] == 2'b00)); // R9

endmodule

// File: rtl/mtest_cmp.sv
module mtest_cmp #(
   parameter int DATA_W   = 32,
   parameter bit CMP_PIPE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rvalid_i,
   input  logic [DATA_W-1:0] rdata_i,
   input  logic [DATA_W-1:0] expect_i,
   output logic              res_valid_o,
   output logic              res_bad_o,
   output logic [DATA_W-1:0] res_mask_o
);
   logic [DATA_W-1:0] diff;
   assign diff = rdata_i ^ expect_i;

   generate
      if (CMP_PIPE) begin : g_pipe
         logic              v_q;
         logic [DATA_W-1:0] m_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               v_q <= 1'b0;
               m_q <= '0;
            end else begin
               v_q <= rvalid_i;
               m_q <= rvalid_i ? diff : '0;
            end
         end
         assign res_valid_o = v_q;
         assign res_mask_o  = m_q;
      end else begin : g_comb
         assign res_valid_o = rvalid_i;
         assign res_mask_o  = rvalid_i ? diff : '0;
      end
   endgenerate

   assign res_bad_o = |res_mask_o;

   AST_RESULT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o |-> !$isunknown(res_mask_o)); // R7

endmodule

// File: rtl/mtest_seq.sv
module mtest_seq
   import mtest_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              empty_i,
   input  logic              last_i,
   input  logic              res_valid_i,
   input  logic              res_bad_i,
   input  logic [DATA_W-1:0] res_mask_i,
   output logic              load_o,
   output logic              clr_o,
   output logic              inc_o,
   output logic              down_o,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   output logic [DATA_W-1:0] expect_o,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] fail_mask_o
);
   state_e            st_q, st_n;
   elem_e             el_q, el_n;
   logic [DATA_W-1:0] mask_q, mask_n;
   logic              adv;

   always_comb begin
      st_n   = st_q;
      el_n   = el_q;
      mask_n = mask_q;
      clr_o  = 1'b0;
      inc_o  = 1'b0;
      load_o = 1'b0;
      adv    = 1'b0;
      unique case (st_q)
         ST_IDLE: if (start_i) begin
            load_o = 1'b1;
            clr_o  = 1'b1;
            mask_n = '0;
            el_n   = EL_FILL0;
            st_n   = empty_i ? ST_DONE : ST_WRITE;
         end
         ST_READ:  st_n = ST_WAIT;
         ST_WAIT:  if (res_valid_i) begin
            if (res_bad_i) begin
               mask_n = mask_q | res_mask_i;
               st_n   = ST_DONE;
            end else if (el_writes(el_q)) begin
               st_n = ST_WRITE;
            end else begin
               adv = 1'b1;
            end
         end
         ST_WRITE: adv  = 1'b1;
         ST_DONE:  st_n = ST_IDLE;
         default:  st_n = ST_IDLE;
      endcase
      if (adv) begin
         if (last_i) begin
            if (el_q == EL_VERIFY) begin
               st_n = ST_DONE;
            end else begin
               el_n  = elem_e'(3'(el_q + 3'd1));
               clr_o = 1'b1;
               st_n  = ST_READ;
            end
         end else begin
            inc_o = 1'b1;
            st_n  = el_reads(el_q) ? ST_READ : ST_WRITE;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         el_q   <= EL_FILL0;
         mask_q <= '0;
      end else begin
         st_q   <= st_n;
         el_q   <= el_n;
         mask_q <= mask_n;
      end
   end

   assign down_o      = el_down(el_q);
   assign mem_req_o   = (st_q == ST_READ) || (st_q == ST_WRITE);
   assign mem_we_o    = (st_q == ST_WRITE);
   assign mem_wdata_o = el_write_ones(el_q) ? '1 : '0;
   assign expect_o    = el_down(el_q) ? '1 : '0;
   assign busy_o      = (st_q != ST_IDLE);
   assign done_o      = (st_q == ST_DONE);
   assign fail_mask_o = mask_q;

   AST_FAIL_STOPS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_i && res_bad_i |=> !mem_req_o && done_o); // R7

   AST_FAIL_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_i && res_bad_i |=> (fail_mask_o != '0)); // R7

endmodule

// File: rtl/mtest_ctrl.sv
module mtest_ctrl #(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter bit CMP_PIPE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [ADDR_W-1:0] end_addr,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] fail_mask,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_rvalid
);
   generate
      if (ADDR_W < 4 || ADDR_W > 64) begin : g_bad_addr_w
         $error("mtest_ctrl: ADDR_W must lie in 4..64");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("mtest_ctrl: DATA_W must be at least 1");
      end
   endgenerate

   logic              load, clr, inc, down, last, empty;
   logic              res_valid, res_bad;
   logic [DATA_W-1:0] res_mask, expect_w;

   mtest_addr #(.ADDR_W(ADDR_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .load_i(load), .base_i(base_addr), .end_i(end_addr),
      .clr_i(clr), .inc_i(inc), .down_i(down), .req_i(mem_req),
      .addr_o(mem_addr), .last_o(last), .empty_o(empty)
   );

   mtest_cmp #(.DATA_W(DATA_W), .CMP_PIPE(CMP_PIPE)) u_cmp (
      .clk(clk), .rst_n(rst_n), .rvalid_i(mem_rvalid), .rdata_i(mem_rdata),
      .expect_i(expect_w), .res_valid_o(res_valid), .res_bad_o(res_bad),
      .res_mask_o(res_mask)
   );

   mtest_seq #(.DATA_W(DATA_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start), .empty_i(empty), .last_i(last),
      .res_valid_i(res_valid), .res_bad_i(res_bad), .res_mask_i(res_mask),
      .load_o(load), .clr_o(clr), .inc_o(inc), .down_o(down),
      .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_wdata_o(mem_wdata),
      .expect_o(expect_w), .busy_o(busy), .done_o(done), .fail_mask_o(fail_mask)
   );

   AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy); // R8

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8

   AST_WDATA_SOLID: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> (mem_wdata == '0) || (mem_wdata == '1)); // R3

   AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !done |=> busy); // R10

endmodule

// File: tb/tb_mtest_ctrl.sv
`timescale 1ns/1ps
module tb_mtest_ctrl;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam logic [31:0] MBASE = 32'h100;
   localparam int MDEPTH = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [AW-1:0] base_addr = '0, end_addr = '0;
   logic busy, done, mem_req, mem_we, mem_rvalid;
   logic [DW-1:0] fail_mask, mem_wdata, mem_rdata;
   logic [AW-1:0] mem_addr;

   always #2.5 clk = ~clk;

   mtest_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .end_addr(end_addr),
      .busy(busy), .done(done), .fail_mask(fail_mask), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid)
   );

   // behavioural RAM with one stuck-bit fault site
   logic [31:0] mem [0:MDEPTH-1];
   int          fault_idx = -1;
   logic [31:0] sa1 = '0, sa0 = '0;
   logic [31:0] tr_addr [0:1023];
   logic        tr_we   [0:1023];
   logic [31:0] tr_data [0:1023];
   int          tr_total = 0;

   function automatic int widx(input logic [31:0] a);
      return int'((a - MBASE) >> 2) % MDEPTH;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_rvalid <= 1'b0;
         mem_rdata  <= '0;
      end else begin
         mem_rvalid <= mem_req && !mem_we;
         if (mem_req) begin
            if (tr_total < 1024) begin
               tr_addr[tr_total] <= mem_addr;
               tr_we[tr_total]   <= mem_we;
               tr_data[tr_total] <= mem_wdata;
            end
            tr_total <= tr_total + 1;
            if (mem_we)
               mem[widx(mem_addr)] <= (widx(mem_addr) == fault_idx) ? ((mem_wdata & ~sa0) | sa1) : mem_wdata;
            else
               mem_rdata <= (widx(mem_addr) == fault_idx) ? ((mem[widx(mem_addr)] & ~sa0) | sa1)
                                                          : mem[widx(mem_addr)];
         end
      end
   end

   int n_chk = 0, n_bad = 0;
   logic [31:0] ex_addr [0:1023];
   logic        ex_we   [0:1023];
   logic [31:0] ex_data [0:1023];
   int          ex_n;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic push(input logic [31:0] a, input logic w, input logic [31:0] d);
      ex_addr[ex_n] = a; ex_we[ex_n] = w; ex_data[ex_n] = d; ex_n++;
   endtask

   // expected full access order for a clean run of n words
   task automatic build(input logic [31:0] b, input int n);
      ex_n = 0;
      for (int i = 0; i < n; i++) push(b + 4*i, 1'b1, 32'h0);
      for (int r = 0; r < 2; r++) begin
         for (int i = 0; i < n; i++) begin
            push(b + 4*i, 1'b0, 32'h0); push(b + 4*i, 1'b1, 32'hFFFF_FFFF);
         end
         for (int i = 0; i < n; i++) begin
            push(b + 4*(n-1-i), 1'b0, 32'h0); push(b + 4*(n-1-i), 1'b1, 32'h0);
         end
      end
      for (int i = 0; i < n; i++) push(b + 4*i, 1'b0, 32'h0);
   endtask

   // compare recorded accesses from index s with the first cnt expected ones
   task automatic cmp_trace(input int s, input int cnt, input string tag);
      int bad_at = -1;
      check(tr_total - s == cnt, {tag, " access count"}, tr_total - s, cnt);
      for (int i = 0; i < cnt && i < tr_total - s; i++)
         if (bad_at < 0 && (tr_addr[s+i] != ex_addr[i] || tr_we[s+i] != ex_we[i] ||
                            (ex_we[i] && tr_data[s+i] != ex_data[i]))) bad_at = i;
      check(bad_at < 0, {tag, " access order"}, (bad_at < 0) ? 32'h0 : tr_addr[s+bad_at],
            (bad_at < 0) ? 32'h0 : ex_addr[bad_at]);
   endtask

   // start a run, optionally pulse start again mid-run; wait for done
   task automatic run(input logic [31:0] b, input logic [31:0] e, input bit glitch, output int s);
      int w = 0;
      s = tr_total;
      @(negedge clk); base_addr = b; end_addr = e; start = 1'b1;
      @(negedge clk); start = 1'b0;
      check(busy == 1'b1, "R8 busy after start", busy, 1);
      if (glitch) begin
         repeat (5) @(negedge clk);
         base_addr = MBASE + 32'h40; end_addr = MBASE + 32'h60; start = 1'b1;
         @(negedge clk); start = 1'b0;
      end
      while (!done && w < 4000) begin
         @(negedge clk); w++;
      end
      check(done == 1'b1, "R8 done seen", done, 1);
      @(negedge clk);
      check(done == 1'b0 && busy == 1'b0, "R8 done single cycle, busy drops", {done, busy}, 0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(busy == 0 && done == 0 && mem_req == 0, "R1 reset outputs", {busy, done, mem_req}, 0);
      check(fail_mask == 0, "R1 reset mask", fail_mask, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 0 && mem_req == 0, "R1 idle after reset", {busy, mem_req}, 0);
   endtask

   task automatic t_pass(input int n, input bit glitch, input string tag);
      int s;
      fault_idx = -1; sa1 = '0; sa0 = '0;
      run(MBASE, MBASE + 4*n, glitch, s);
      build(MBASE, n);
      cmp_trace(s, 10*n, tag);
      check(fail_mask == 0, {tag, " R8 pass mask zero"}, fail_mask, 0);
   endtask

   task automatic t_empty();
      int s;
      run(MBASE + 32'h20, MBASE + 32'h20, 1'b0, s);
      check(tr_total == s, "R9 equal addresses no access", tr_total - s, 0);
      check(fail_mask == 0, "R9 equal addresses mask", fail_mask, 0);
      run(MBASE + 32'h20, MBASE + 32'h10, 1'b0, s);
      check(tr_total == s, "R9 end below base no access", tr_total - s, 0);
   endtask

   task automatic t_stuck1();
      int s;
      fault_idx = 3; sa1 = 32'h0000_0020; sa0 = '0;
      run(MBASE, MBASE + 32, 1'b0, s);
      build(MBASE, 8);
      cmp_trace(s, 8 + 2*3 + 1, "R7 R3 stuck-at-1 stop point");
      check(tr_addr[tr_total-1] == MBASE + 12, "R7 last access is faulty word", tr_addr[tr_total-1], MBASE + 12);
      check(fail_mask == 32'h20, "R7 stuck-at-1 mask", fail_mask, 32'h20);
      repeat (6) @(negedge clk);
      check(fail_mask == 32'h20 && tr_total == s + 15, "R11 mask held, no access after fail",
            fail_mask, 32'h20);
   endtask

   task automatic t_stuck0();
      int s;
      fault_idx = 2; sa1 = '0; sa0 = 32'h0000_0200;
      run(MBASE, MBASE + 32, 1'b0, s);
      build(MBASE, 8);
      cmp_trace(s, 8 + 16 + 2*5 + 1, "R7 R4 stuck-at-0 stop point");
      check(fail_mask == 32'h200, "R7 stuck-at-0 mask", fail_mask, 32'h200);
   endtask

   initial begin
      #750000;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < MDEPTH; i++) mem[i] = 32'hA5A5_0000 + i;
      t_reset();
      t_pass(8, 1'b0, "R2 R3 R4 R5 R6 eight words");
      t_pass(1, 1'b0, "R2 R6 one word");
      t_empty();
      t_stuck1();
      t_pass(8, 1'b0, "R11 clean run after fail");
      t_stuck0();
      t_pass(8, 1'b1, "R10 start while busy");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule